// File: doc/BRIEF.md
# Multi-mode Timer Counter Core

This block is a 16-bit counter that runs against a programmable limit value. It can count upward and wrap, count downward and reload, or count up and back down between zero and the limit for centre-aligned timing. The counter moves only on cycles where the counter clock enable is high and the counter is running. At the turning points it emits single-cycle overflow, underflow and update pulses. The update pulse marks the point where a surrounding design would swap in buffered settings.

Software controls the counter through plain ports. Start and stop strobes set or clear the running state, and a write strobe loads any 16-bit value into the counter. An asynchronous trigger input passes through a synchroniser. Its rising and falling edges each have their own action select, which can start, stop or reload the counter. The reload value depends on the counting mode.

Top module: `wave_timer`

## Requirements
- R1: With `mode_sel` = 2'b00 (2'b11 behaves the same), a running counter that is ticked increments. On the tick where it equals `top_val`, it becomes 0.
- R2: With `mode_sel` = 2'b01, a ticked counter decrements. On the tick where it equals 0, it becomes `top_val`.
- R3: With `mode_sel` = 2'b10, the counter climbs to `top_val` and then turns: the next value is `top_val`-1 and counting continues downward. At 0 it turns again: the next value is 1 and counting continues upward. A reload restores the upward direction. `top_val` is at least 1 in this mode.
- R4: `ovf_pulse` is high for exactly the cycle after a tick that moved the counter off `top_val` while counting upward, in up mode and in up/down mode.
- R5: `unf_pulse` is high for exactly the cycle after a tick that moved the counter off 0 while counting downward, in down mode and in up/down mode.
- R6: `upd_pulse` equals `ovf_pulse` in up mode, and equals `unf_pulse` in down mode and in up/down mode.
- R7: A `sw_start` strobe sets `running` from the next cycle, and a `sw_stop` strobe clears it. If any stop request and any start request arrive in the same cycle, the counter is stopped.
- R8: A `sw_wr` strobe places `sw_wr_data` in `cnt` on the next cycle. This overrides counting and trigger reload in that cycle and raises no flag. A value above `top_val` in up mode keeps counting and wraps through 16'hFFFF to 0 without `ovf_pulse`.
- R9: The trigger passes through a two-flop synchroniser. A level change of `trig_in` sampled at clock edge k is acted on at edge k+2. The action codes for `rise_act` and `fall_act` are: 0 = none, 1 = start, 2 = stop, 3 = reload.
- R10: A reload action loads 0 in up and up/down modes and loads `top_val` in down mode. It raises no flag.
- R11: The count holds, and no flag pulses, on cycles where `tick_en` is low or the counter is stopped, unless a write or reload occurs.
- R12: After reset, `cnt` is 0, `running` is 0, all pulses are 0 and the up/down direction is upward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | Counter clock enable |
| mode_sel | input | 2 | 00 up, 01 down, 10 up/down, 11 up |
| top_val | input | 16 | Limit value |
| sw_start | input | 1 | Start strobe |
| sw_stop | input | 1 | Stop strobe |
| sw_wr | input | 1 | Counter write strobe |
| sw_wr_data | input | 16 | Value for counter write |
| trig_in | input | 1 | Asynchronous trigger input |
| rise_act | input | 2 | Action on trigger rising edge |
| fall_act | input | 2 | Action on trigger falling edge |
| cnt | output | 16 | Counter value |
| running | output | 1 | Counter running state |
| ovf_pulse | output | 1 | Overflow pulse |
| unf_pulse | output | 1 | Underflow pulse |
| upd_pulse | output | 1 | Update event pulse |

## Verification
Two pairs of functions can collide in one cycle: a software counter write against a trigger reload, and a start request against a stop request. The bench drives `sw_wr` in the same cycle that a synchronised trigger edge requests a reload. It also raises `sw_start` and `sw_stop` together, and pairs a trigger start with a software stop. A behavioural model applies the stated priorities, write before reload and stop before start. It is compared with the counter, the running state and all three pulses on every cycle.

// File: rtl/wave_timer_pkg.sv
package wave_timer_pkg;

  localparam int CNT_W = 16;
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  typedef enum logic [1:0] {
    MODE_UP     = 2'd0,
    MODE_DOWN   = 2'd1,
    MODE_UPDOWN = 2'd2,
    MODE_UP_ALT = 2'd3
  } cnt_mode_e;

  typedef enum logic [1:0] {
    ACT_NONE   = 2'd0,
    ACT_START  = 2'd1,
    ACT_STOP   = 2'd2,
    ACT_RELOAD = 2'd3
  } trig_act_e;

  typedef struct packed {
    logic [CNT_W-1:0] nxt;
    logic             going_down;
    logic             ovf;
    logic             unf;
  } step_t;

  // One counting tick: next value, direction and turning-point flags.
  function automatic step_t count_step(cnt_mode_e mode, logic [CNT_W-1:0] cur,
                                       logic [CNT_W-1:0] top, logic going_down);
    step_t s;
    s.nxt        = cur;
    s.going_down = going_down;
    s.ovf        = 1'b0;
    s.unf        = 1'b0;
    case (mode)
      MODE_DOWN: begin
        if (cur == '0) begin
          s.nxt = top;
          s.unf = 1'b1;
        end else begin
          s.nxt = cur - CNT_ONE;
        end
      end
      MODE_UPDOWN: begin
        if (going_down) begin
          if (cur == '0) begin
            s.nxt        = CNT_ONE;
            s.going_down = 1'b0;
            s.unf        = 1'b1;
          end else begin
            s.nxt = cur - CNT_ONE;
          end
        end else if (cur == top) begin
          s.nxt        = top - CNT_ONE;
          s.going_down = 1'b1;
          s.ovf        = 1'b1;
        end else begin
          s.nxt = cur + CNT_ONE;
        end
      end
      default: begin
        if (cur == top) begin
          s.nxt = '0;
          s.ovf = 1'b1;
        end else begin
          s.nxt = cur + CNT_ONE;
        end
      end
    endcase
    return s;
  endfunction

  function automatic logic [CNT_W-1:0] reload_value(cnt_mode_e mode, logic [CNT_W-1:0] top);
    return (mode == MODE_DOWN) ? top : '0;
  endfunction

  function automatic logic update_source(cnt_mode_e mode, logic ovf, logic unf);
    return (mode == MODE_DOWN || mode == MODE_UPDOWN) ? unf : ovf;
  endfunction

  function automatic logic act_is(logic [1:0] act, trig_act_e want, logic edge_seen);
    return edge_seen && (trig_act_e'(act) == want);
  endfunction

endpackage

// File: rtl/wt_trig_edge.sv
module wt_trig_edge
  import wave_timer_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       trig_in,
  input  logic [1:0] rise_act,
  input  logic [1:0] fall_act,
  output logic       trig_start,
  output logic       trig_stop,
  output logic       trig_reload
);
  localparam int LAST = SYNC_STAGES - 1;

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   prev_q;
  logic                   rise_seen;
  logic                   fall_seen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q[0] <= trig_in;
      prev_q    <= sync_q[LAST];
      for (int i = 1; i < SYNC_STAGES; i++) sync_q[i] <= sync_q[i-1];
    end
  end

  assign rise_seen = sync_q[LAST] && !prev_q;
  assign fall_seen = !sync_q[LAST] && prev_q;

  assign trig_start  = act_is(rise_act, ACT_START, rise_seen)  || act_is(fall_act, ACT_START, fall_seen);
  assign trig_stop   = act_is(rise_act, ACT_STOP, rise_seen)   || act_is(fall_act, ACT_STOP, fall_seen);
  assign trig_reload = act_is(rise_act, ACT_RELOAD, rise_seen) || act_is(fall_act, ACT_RELOAD, fall_seen);
endmodule

// File: rtl/wt_run_ctrl.sv
module wt_run_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic sw_start,
  input  logic sw_stop,
  input  logic trig_start,
  input  logic trig_stop,
  output logic start_evt,
  output logic stop_evt,
  output logic run_o
);
  assign start_evt = sw_start || trig_start;
  assign stop_evt  = sw_stop || trig_stop;

  // Stop takes precedence over start.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         run_o <= 1'b0;
    else if (stop_evt)  run_o <= 1'b0;
    else if (start_evt) run_o <= 1'b1;
  end
endmodule

// File: rtl/wt_count_reg.sv
module wt_count_reg
  import wave_timer_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       mode_sel,
  input  logic [CNT_W-1:0] top_val,
  input  logic             run,
  input  logic             tick_en,
  input  logic             wr,
  input  logic [CNT_W-1:0] wr_data,
  input  logic             reload,
  output logic [CNT_W-1:0] cnt_o,
  output logic             adv_o,
  output logic             ovf_o,
  output logic             unf_o,
  output logic             upd_o
);
  cnt_mode_e mode;
  step_t     step;
  logic      down_q;
  logic      counting;

  assign mode     = cnt_mode_e'(mode_sel);
  assign adv_o    = run && tick_en;
  assign counting = adv_o && !wr && !reload;
  assign step     = count_step(mode, cnt_o, top_val, down_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_o  <= '0;
      down_q <= 1'b0;
    end else if (wr) begin
      cnt_o <= wr_data;
    end else if (reload) begin
      cnt_o  <= reload_value(mode, top_val);
      down_q <= 1'b0;
    end else if (adv_o) begin
      cnt_o  <= step.nxt;
      down_q <= step.going_down;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ovf_o <= 1'b0;
      unf_o <= 1'b0;
      upd_o <= 1'b0;
    end else begin
      ovf_o <= counting && step.ovf;
      unf_o <= counting && step.unf;
      upd_o <= counting && update_source(mode, step.ovf, step.unf);
    end
  end
endmodule

// File: rtl/wave_timer.sv
module wave_timer
  import wave_timer_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_en,
  input  logic [1:0]       mode_sel,
  input  logic [CNT_W-1:0] top_val,
  input  logic             sw_start,
  input  logic             sw_stop,
  input  logic             sw_wr,
  input  logic [CNT_W-1:0] sw_wr_data,
  input  logic             trig_in,
  input  logic [1:0]       rise_act,
  input  logic [1:0]       fall_act,
  output logic [CNT_W-1:0] cnt,
  output logic             running,
  output logic             ovf_pulse,
  output logic             unf_pulse,
  output logic             upd_pulse
);
  logic trig_start;
  logic trig_stop;
  logic reload_evt;
  logic start_evt;
  logic stop_evt;
  logic adv;

  wt_trig_edge #(.SYNC_STAGES(SYNC_STAGES)) trig_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .trig_in    (trig_in),
    .rise_act   (rise_act),
    .fall_act   (fall_act),
    .trig_start (trig_start),
    .trig_stop  (trig_stop),
    .trig_reload(reload_evt)
  );

  wt_run_ctrl run_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .sw_start  (sw_start),
    .sw_stop   (sw_stop),
    .trig_start(trig_start),
    .trig_stop (trig_stop),
    .start_evt (start_evt),
    .stop_evt  (stop_evt),
    .run_o     (running)
  );

  wt_count_reg cnt_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .mode_sel(mode_sel),
    .top_val (top_val),
    .run     (running),
    .tick_en (tick_en),
    .wr      (sw_wr),
    .wr_data (sw_wr_data),
    .reload  (reload_evt),
    .cnt_o   (cnt),
    .adv_o   (adv),
    .ovf_o   (ovf_pulse),
    .unf_o   (unf_pulse),
    .upd_o   (upd_pulse)
  );
endmodule

// File: rtl/wave_timer_chk.sv
module wave_timer_chk
  import wave_timer_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             tick_en,
  input logic [1:0]       mode_sel,
  input logic [CNT_W-1:0] top_val,
  input logic             sw_wr,
  input logic [CNT_W-1:0] sw_wr_data,
  input logic [CNT_W-1:0] cnt,
  input logic             running,
  input logic             ovf_pulse,
  input logic             unf_pulse,
  input logic             upd_pulse,
  input logic             adv,
  input logic             reload_evt,
  input logic             stop_evt
);
  // R1
  up_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(adv && !sw_wr && !reload_evt && (mode_sel == 2'd0) && cnt == top_val)
      |-> (cnt == '0) && ovf_pulse);
  // R2
  down_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(adv && !sw_wr && !reload_evt && (mode_sel == 2'd1) && cnt == '0)
      |-> (cnt == $past(top_val)) && unf_pulse);
  // R4
  ovf_from_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_pulse |-> $past(cnt) == $past(top_val));
  // R5
  unf_from_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    unf_pulse |-> $past(cnt) == '0);
  // R6
  upd_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    upd_pulse == (($past(mode_sel) == 2'd1 || $past(mode_sel) == 2'd2) ? unf_pulse : ovf_pulse));
  // R7
  stop_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(stop_evt) |-> !running);
  // R8
  write_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(sw_wr) |-> (cnt == $past(sw_wr_data)) && !ovf_pulse && !unf_pulse);
  // R10
  reload_val_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(reload_evt && !sw_wr)
      |-> cnt == (($past(mode_sel) == 2'd1) ? $past(top_val) : '0));
  // R11
  flag_needs_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_pulse || unf_pulse || upd_pulse) |-> $past(running && tick_en));
  // R11
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!adv && !sw_wr && !reload_evt) |-> $stable(cnt));
endmodule

bind wave_timer wave_timer_chk chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .tick_en   (tick_en),
  .mode_sel  (mode_sel),
  .top_val   (top_val),
  .sw_wr     (sw_wr),
  .sw_wr_data(sw_wr_data),
  .cnt       (cnt),
  .running   (running),
  .ovf_pulse (ovf_pulse),
  .unf_pulse (unf_pulse),
  .upd_pulse (upd_pulse),
  .adv       (adv),
  .reload_evt(reload_evt),
  .stop_evt  (stop_evt)
);

// File: tb/wave_timer_tb_top.sv
`timescale 1ns/1ps
module wave_timer_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_en = 1'b0;
  logic [1:0]  mode_sel = 2'd0;
  logic [15:0] top_val = 16'd0;
  logic        sw_start = 1'b0;
  logic        sw_stop = 1'b0;
  logic        sw_wr = 1'b0;
  logic [15:0] sw_wr_data = 16'd0;
  logic        trig_in = 1'b0;
  logic [1:0]  rise_act = 2'd0;
  logic [1:0]  fall_act = 2'd0;
  logic [15:0] cnt;
  logic        running, ovf_pulse, unf_pulse, upd_pulse;

  int    checks = 0;
  int    errors = 0;
  string cur_req = "R12";

  always #2.5 clk = ~clk;

  wave_timer dut_i (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .mode_sel(mode_sel),
    .top_val(top_val), .sw_start(sw_start), .sw_stop(sw_stop), .sw_wr(sw_wr),
    .sw_wr_data(sw_wr_data), .trig_in(trig_in), .rise_act(rise_act),
    .fall_act(fall_act), .cnt(cnt), .running(running), .ovf_pulse(ovf_pulse),
    .unf_pulse(unf_pulse), .upd_pulse(upd_pulse)
  );

  // Behavioural reference model, advanced on each rising edge.
  int m_cnt = 0;
  bit m_run = 0, m_down = 0, m_ovf = 0, m_unf = 0, m_upd = 0;
  bit t1 = 0, t2 = 0, t3 = 0;
  bit rise, fall, go, halt, rl, adv;
  int md;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cnt = 0; m_run = 0; m_down = 0; m_ovf = 0; m_unf = 0; m_upd = 0;
      t1 = 0; t2 = 0; t3 = 0;
    end else begin
      rise = t2 && !t3;
      fall = !t2 && t3;
      go   = sw_start || (rise && rise_act == 1) || (fall && fall_act == 1);
      halt = sw_stop  || (rise && rise_act == 2) || (fall && fall_act == 2);
      rl   = (rise && rise_act == 3) || (fall && fall_act == 3);
      adv  = m_run && tick_en;
      md   = (mode_sel == 3) ? 0 : int'(mode_sel);
      m_ovf = 0; m_unf = 0; m_upd = 0;
      if (sw_wr) m_cnt = int'(sw_wr_data);
      else if (rl) begin
        m_cnt  = (md == 1) ? int'(top_val) : 0;
        m_down = 0;
      end else if (adv) begin
        if (md == 0) begin
          if (m_cnt == int'(top_val)) begin m_cnt = 0; m_ovf = 1; end
          else m_cnt = (m_cnt + 1) & 'hFFFF;
        end else if (md == 1) begin
          if (m_cnt == 0) begin m_cnt = int'(top_val); m_unf = 1; end
          else m_cnt = m_cnt - 1;
        end else if (!m_down) begin
          if (m_cnt == int'(top_val)) begin m_cnt = int'(top_val) - 1; m_down = 1; m_ovf = 1; end
          else m_cnt = (m_cnt + 1) & 'hFFFF;
        end else begin
          if (m_cnt == 0) begin m_cnt = 1; m_down = 0; m_unf = 1; end
          else m_cnt = m_cnt - 1;
        end
        m_upd = (md == 0) ? m_ovf : m_unf;
      end
      if (halt) m_run = 0;
      else if (go) m_run = 1;
      t3 = t2; t2 = t1; t1 = trig_in;
    end
  end

  task automatic check(bit ok, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", cur_req, what, act, exp);
    end
  endtask

  // Wait for the falling edge, then compare every output with the model.
  task automatic cyc();
    @(negedge clk);
    check(int'(cnt) == m_cnt, "cnt", int'(cnt), m_cnt);
    check(running == m_run, "running", int'(running), int'(m_run));
    check(ovf_pulse == m_ovf, "ovf_pulse", int'(ovf_pulse), int'(m_ovf));
    check(unf_pulse == m_unf, "unf_pulse", int'(unf_pulse), int'(m_unf));
    check(upd_pulse == m_upd, "upd_pulse", int'(upd_pulse), int'(m_upd));
  endtask

  task automatic run_for(int n);
    for (int i = 0; i < n; i++) cyc();
  endtask

  task automatic pulse_start(); sw_start = 1; cyc(); sw_start = 0; endtask
  task automatic pulse_stop();  sw_stop = 1;  cyc(); sw_stop = 0;  endtask
  task automatic write_cnt(int v); sw_wr = 1; sw_wr_data = 16'(v); cyc(); sw_wr = 0; endtask

  task automatic finish_up();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL %s watchdog actual=%0d expected=%0d", cur_req, 1, 0);
    finish_up();
  end

  initial begin
    // R12: reset state
    run_for(3);
    @(negedge clk); rst_n = 1;
    cur_req = "R12";
    check(cnt == 0 && !running && !ovf_pulse && !unf_pulse && !upd_pulse,
          "reset outputs", int'(cnt), 0);
    run_for(2);

    // R1 R4 R6: up mode wrap at limit
    cur_req = "R1 R4 R6";
    mode_sel = 2'd0; top_val = 16'd5; tick_en = 1;
    pulse_start();
    run_for(20);

    // R11: gated ticks, then stopped counter holds
    cur_req = "R11";
    for (int i = 0; i < 24; i++) begin
      tick_en = (i % 3 == 0);
      cyc();
    end
    tick_en = 1;
    pulse_stop();
    run_for(6);

    // R2 R5 R6: down mode
    cur_req = "R2 R5 R6";
    mode_sel = 2'd1; top_val = 16'd4;
    write_cnt(2);
    pulse_start();
    run_for(16);

    // R3 R4 R5 R6: up/down turning points
    cur_req = "R3 R4 R5 R6";
    mode_sel = 2'd2; top_val = 16'd3;
    rise_act = 2'd3; trig_in = 1; run_for(4); rise_act = 2'd0;
    run_for(20);
    trig_in = 0; run_for(3);

    // R7: simultaneous start and stop, then each alone
    cur_req = "R7";
    sw_start = 1; sw_stop = 1; cyc(); sw_start = 0; sw_stop = 0;
    run_for(3);
    pulse_start(); run_for(2);
    sw_start = 1; sw_stop = 1; cyc(); sw_start = 0; sw_stop = 0;
    run_for(3);
    pulse_start(); run_for(3);

    // R8: write while counting, write against trigger reload, value above limit
    cur_req = "R8";
    mode_sel = 2'd0; top_val = 16'd9;
    write_cnt(7); run_for(4);
    rise_act = 2'd3; trig_in = 1; cyc(); cyc();
    write_cnt(100);
    run_for(3); rise_act = 2'd0; trig_in = 0; run_for(3);
    write_cnt(16'hFFFE); run_for(5);

    // R9: trigger rise starts, fall stops; trigger start against software stop
    cur_req = "R9";
    pulse_stop();
    rise_act = 2'd1; fall_act = 2'd2;
    for (int k = 0; k < 3; k++) begin
      trig_in = 1; run_for(5);
      trig_in = 0; run_for(5);
    end
    trig_in = 1; cyc(); cyc(); sw_stop = 1; cyc(); sw_stop = 0; run_for(3);
    trig_in = 0; run_for(4);
    rise_act = 2'd0; fall_act = 2'd0;
    trig_in = 1; run_for(4); trig_in = 0; run_for(4);

    // R10: reload value per mode
    cur_req = "R10";
    pulse_start();
    mode_sel = 2'd1; top_val = 16'd12; fall_act = 2'd3;
    run_for(3); trig_in = 1; run_for(3); trig_in = 0; run_for(6);
    mode_sel = 2'd0; top_val = 16'd30;
    run_for(4); trig_in = 1; run_for(3); trig_in = 0; run_for(6);
    mode_sel = 2'd2; top_val = 16'd2;
    run_for(7); trig_in = 1; run_for(3); trig_in = 0; run_for(8);
    mode_sel = 2'd3; top_val = 16'd3; fall_act = 2'd0;
    run_for(10);

    finish_up();
  end
endmodule